// File: doc/BRIEF.md
# Dual-Density Floppy Interface Glue

This block sits between a byte-wide CPU I/O bus and a floppy disk controller that can run drives in either high-density or double-density form. It decodes CPU reads and writes, passes accesses to the controller's status and data ports through to it, and holds two small registers of its own. The control register drives the controller's reset, drive-ready and motor lines. The mode register selects the drive density.

Mode bit 0 picks which of two address sets the controller ports answer on. The two sets differ only in address bit `SET_BIT`. Mode bit 1 picks the density. The density in turn steers the controller's interrupt and DMA request to one of two interrupt inputs and one of two DMA channels, and the steering follows the mode at run time.

A status byte reports fixed strap settings and a disk-present flag. A one-shot interval timer restarts on every control write. When it expires it can raise an interrupt, which is steered the same way as the controller interrupt.

Top module: `fdd_bridge`

## Requirements
- R1: After reset the control and mode registers read as zero. `fdc_rst`, `fdc_ready`, `fdc_motor`, `dens_hd` and all four routed request outputs are 0 while the controller requests are idle. A read at the mode address returns 0xF8.
- R2: A control write that sets bit 7 while the stored bit 7 is 0 drives `fdc_rst` high for `RST_LEN` cycles, starting in the cycle after the write. A control write with bit 7 already set gives no pulse.
- R3: `fdc_ready` equals stored control bit 6 and `fdc_motor` equals stored control bit 3, both from the cycle after the write.
- R4: Every control write clears the timer interrupt and restarts a one-shot count of `TIMER_CYCLES` cycles. At expiry the timer interrupt rises, but only if control bit 2 is 1 at that time. It then stays high until the next control write.
- R5: The controller status port (fold address `BASE`, `fdc_a0`=0) and data port (fold `BASE`+2, `fdc_a0`=1) are reached only when address bit `SET_BIT` equals mode bit 0. The fold address is the address with bit `SET_BIT` cleared. A reached port passes `fdc_rd`/`fdc_wr` and returns `fdc_rdata`. Otherwise there is no strobe and a read gives 0xFF.
- R6: A write at address `BASE`+0x0E stores data bits 1:0 as the mode. A read there returns 0xF8 OR the mode.
- R7: `dens_hd` goes to 1 when mode bit 1 changes from 0 to 1, and back to 0 when it changes from 1 to 0.
- R8: A read at fold address `BASE`+4 returns 0x64, with bit 4 also set when `disk_in` is 1.
- R9: With `dens_hd`=1 the interrupt source goes to `irq_ir3` and `fdc_drq` to `drq_ch2`. With `dens_hd`=0 they go to `irq_ir2` and `drq_ch3`. The interrupt source is `fdc_int` OR the timer interrupt. The unselected outputs stay 0.
- R10: Reads at any other address return 0xFF. Writes there assert no controller strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | CPU I/O address |
| io_wr | input | 1 | CPU write strobe |
| io_rd | input | 1 | CPU read strobe |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | CPU read data |
| fdc_rd | output | 1 | Controller read strobe |
| fdc_wr | output | 1 | Controller write strobe |
| fdc_a0 | output | 1 | Controller port select (0 status, 1 data) |
| fdc_wdata | output | 8 | Write data to controller |
| fdc_rdata | input | 8 | Read data from controller |
| fdc_rst | output | 1 | Controller reset pulse |
| fdc_ready | output | 1 | Drive-ready to controller |
| fdc_motor | output | 1 | Drive motor enable |
| fdc_int | input | 1 | Controller interrupt |
| fdc_drq | input | 1 | Controller DMA request |
| disk_in | input | 1 | Disk-present flag |
| dens_hd | output | 1 | Drives 0 and 1 are high density |
| irq_ir3 | output | 1 | Interrupt input 3 |
| irq_ir2 | output | 1 | Interrupt input 2 |
| drq_ch2 | output | 1 | DMA channel 2 request |
| drq_ch3 | output | 1 | DMA channel 3 request |

## Verification
The bench keeps `BASE`=0x20 and `SET_BIT`=4, so the 8-bit address space holds only 256 addresses. It sweeps every one of them for reads under all four mode values and for writes under both address-set selections. The expected data and strobes come from an arithmetic decode written into the bench.

`TIMER_CYCLES` is cut to 50 and `RST_LEN` to 3. This lets the bench check the exact expiry cycle, retriggering before expiry, and the exact reset-pulse length within a short run.

// File: rtl/fdd_bridge_pkg.sv
package fdd_bridge_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_FSTAT,
      SEL_FDATA,
      SEL_CTRL,
      SEL_MODE
   } sel_e;

   localparam logic [7:0] STAT_STRAPS = 8'h64;
   localparam logic [7:0] OPEN_BUS    = 8'hFF;

   function automatic logic [7:0] mode_byte(input logic [1:0] m);
      return {6'b111110, m};
   endfunction

   function automatic logic [7:0] stat_byte(input logic disk);
      return STAT_STRAPS | {3'b000, disk, 4'b0000};
   endfunction

endpackage

// File: rtl/fdd_bridge_decode.sv
module fdd_bridge_decode
   import fdd_bridge_pkg::*;
#(
   parameter int          ADDR_W = 8,
   parameter int          SET_BIT = 4,
   parameter logic [ADDR_W-1:0] BASE = 'h20
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              mode_set,
   output sel_e              sel,
   output logic              set_ok
);

   localparam logic [ADDR_W-1:0] SET_MASK  = ADDR_W'(1) << SET_BIT;
   localparam logic [ADDR_W-1:0] A_FSTAT   = BASE;
   localparam logic [ADDR_W-1:0] A_FDATA   = BASE + ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_CTRL    = BASE + ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_MODE    = BASE + ADDR_W'(14);

   logic [ADDR_W-1:0] fold;

   always_comb begin
      fold = io_addr & ~SET_MASK;
      if (fold == A_FSTAT)        sel = SEL_FSTAT;
      else if (fold == A_FDATA)   sel = SEL_FDATA;
      else if (fold == A_CTRL)    sel = SEL_CTRL;
      else if (io_addr == A_MODE) sel = SEL_MODE;
      else                        sel = SEL_NONE;
      set_ok = (io_addr[SET_BIT] == mode_set);
   end

endmodule

// File: rtl/fdd_bridge_regs.sv
module fdd_bridge_regs #(
   parameter int RST_LEN = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_we,
   input  logic       mode_we,
   input  logic [7:0] wdata,
   output logic [7:0] ctrl_q,
   output logic [1:0] mode_q,
   output logic       dens_hd,
   output logic       fdc_rst
);

   logic rst_fire;

   assign rst_fire = ctrl_we && wdata[7] && !ctrl_q[7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         mode_q  <= '0;
         dens_hd <= 1'b0;
      end else begin
         if (ctrl_we) ctrl_q <= wdata;
         if (mode_we) begin
            mode_q <= wdata[1:0];
            if (!mode_q[1] && wdata[1])      dens_hd <= 1'b1;
            else if (mode_q[1] && !wdata[1]) dens_hd <= 1'b0;
         end
      end
   end

   generate
      if (RST_LEN == 1) begin : g_rst_flop
         always_ff @(posedge clk) begin
            if (!rst_n) fdc_rst <= 1'b0;
            else        fdc_rst <= rst_fire;
         end
      end else begin : g_rst_count
         localparam int RW = $clog2(RST_LEN + 1);
         logic [RW-1:0] rcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)               rcnt <= '0;
            else if (rst_fire)        rcnt <= RW'(RST_LEN);
            else if (rcnt != '0)      rcnt <= rcnt - RW'(1);
         end
         assign fdc_rst = (rcnt != '0);
      end
   endgenerate

endmodule

// File: rtl/fdd_bridge_timer.sv
module fdd_bridge_timer #(
   parameter int CYCLES = 12_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic arm,
   output logic irq
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
         irq <= 1'b0;
      end else if (restart) begin
         cnt <= CW'(CYCLES);
         run <= 1'b1;
         irq <= 1'b0;
      end else if (run) begin
         if (cnt == CW'(1)) begin
            run <= 1'b0;
            irq <= arm;
         end else begin
            cnt <= cnt - CW'(1);
         end
      end
   end

endmodule

// File: rtl/fdd_bridge_route.sv
module fdd_bridge_route #(
   parameter bit HD_ON_IR3 = 1'b1
) (
   input  logic hd,
   input  logic int_src,
   input  logic drq_src,
   output logic irq_ir3,
   output logic irq_ir2,
   output logic drq_ch2,
   output logic drq_ch3
);

   generate
      if (HD_ON_IR3) begin : g_hd_high
         assign irq_ir3 = hd  & int_src;
         assign irq_ir2 = !hd & int_src;
         assign drq_ch2 = hd  & drq_src;
         assign drq_ch3 = !hd & drq_src;
      end else begin : g_hd_low
         assign irq_ir3 = !hd & int_src;
         assign irq_ir2 = hd  & int_src;
         assign drq_ch2 = !hd & drq_src;
         assign drq_ch3 = hd  & drq_src;
      end
   endgenerate

endmodule

// File: rtl/fdd_bridge.sv
module fdd_bridge
   import fdd_bridge_pkg::*;
#(
   parameter int                ADDR_W       = 8,
   parameter int                SET_BIT      = 4,
   parameter logic [ADDR_W-1:0] BASE         = 'h20,
   parameter int                TIMER_CYCLES = 12_500_000,
   parameter int                RST_LEN      = 4,
   parameter bit                HD_ON_IR3    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              fdc_rd,
   output logic              fdc_wr,
   output logic              fdc_a0,
   output logic [7:0]        fdc_wdata,
   input  logic [7:0]        fdc_rdata,
   output logic              fdc_rst,
   output logic              fdc_ready,
   output logic              fdc_motor,
   input  logic              fdc_int,
   input  logic              fdc_drq,
   input  logic              disk_in,
   output logic              dens_hd,
   output logic              irq_ir3,
   output logic              irq_ir2,
   output logic              drq_ch2,
   output logic              drq_ch3
);

   initial begin
      assert (SET_BIT >= 0 && SET_BIT < ADDR_W) else $error("SET_BIT outside address");
      assert (SET_BIT > 3) else $error("SET_BIT overlaps register offsets");
      assert (BASE[SET_BIT] == 1'b0) else $error("BASE must have SET_BIT clear");
      assert (TIMER_CYCLES >= 2) else $error("TIMER_CYCLES too small");
      assert (RST_LEN >= 1) else $error("RST_LEN must be at least 1");
   end

   sel_e       sel;
   logic       set_ok;
   logic [7:0] ctrl_q;
   logic [1:0] mode_q;
   logic       tmr_irq;
   logic       port_hit;
   logic       ctrl_we;
   logic       mode_we;

   fdd_bridge_decode #(
      .ADDR_W (ADDR_W),
      .SET_BIT(SET_BIT),
      .BASE   (BASE)
   ) i_decode (
      .io_addr (io_addr),
      .mode_set(mode_q[0]),
      .sel     (sel),
      .set_ok  (set_ok)
   );

   assign port_hit  = set_ok && (sel == SEL_FSTAT || sel == SEL_FDATA);
   assign ctrl_we   = io_wr && (sel == SEL_CTRL);
   assign mode_we   = io_wr && (sel == SEL_MODE);
   assign fdc_wr    = io_wr && port_hit;
   assign fdc_rd    = io_rd && port_hit;
   assign fdc_a0    = (sel == SEL_FDATA);
   assign fdc_wdata = io_wdata;

   fdd_bridge_regs #(
      .RST_LEN(RST_LEN)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl_we(ctrl_we),
      .mode_we(mode_we),
      .wdata  (io_wdata),
      .ctrl_q (ctrl_q),
      .mode_q (mode_q),
      .dens_hd(dens_hd),
      .fdc_rst(fdc_rst)
   );

   assign fdc_ready = ctrl_q[6];
   assign fdc_motor = ctrl_q[3];

   fdd_bridge_timer #(
      .CYCLES(TIMER_CYCLES)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(ctrl_we),
      .arm    (ctrl_q[2]),
      .irq    (tmr_irq)
   );

   fdd_bridge_route #(
      .HD_ON_IR3(HD_ON_IR3)
   ) i_route (
      .hd     (dens_hd),
      .int_src(fdc_int | tmr_irq),
      .drq_src(fdc_drq),
      .irq_ir3(irq_ir3),
      .irq_ir2(irq_ir2),
      .drq_ch2(drq_ch2),
      .drq_ch3(drq_ch3)
   );

   always_comb begin
      unique case (sel)
         SEL_FSTAT, SEL_FDATA: io_rdata = set_ok ? fdc_rdata : OPEN_BUS;
         SEL_CTRL:             io_rdata = stat_byte(disk_in);
         SEL_MODE:             io_rdata = mode_byte(mode_q);
         default:              io_rdata = OPEN_BUS;
      endcase
   end

endmodule

// File: rtl/fdd_bridge_chk.sv
module fdd_bridge_chk #(
   parameter int                ADDR_W  = 8,
   parameter int                SET_BIT = 4,
   parameter logic [ADDR_W-1:0] BASE    = 'h20
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic              fdc_rst,
   input logic              fdc_ready,
   input logic              fdc_motor,
   input logic              fdc_wr,
   input logic              dens_hd,
   input logic              irq_ir3,
   input logic              irq_ir2,
   input logic              drq_ch2,
   input logic              drq_ch3,
   input logic [7:0]        ctrl_q,
   input logic [1:0]        mode_q,
   input logic              tmr_irq
);

   localparam logic [ADDR_W-1:0] MASK = ~(ADDR_W'(1) << SET_BIT);

   logic c_wr;
   logic m_wr;

   assign c_wr = io_wr && ((io_addr & MASK) == BASE + ADDR_W'(4));
   assign m_wr = io_wr && (io_addr == BASE + ADDR_W'(14));

   AST_RST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr && io_wdata[7] && !ctrl_q[7] |=> fdc_rst); // R2
   AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fdc_rst) |-> $past(c_wr && io_wdata[7] && !ctrl_q[7])); // R2
   AST_LINES_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr |=> (fdc_ready == $past(io_wdata[6])) && (fdc_motor == $past(io_wdata[3]))); // R3
   AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr |=> !tmr_irq); // R4
   AST_PORT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      fdc_wr |-> io_addr[SET_BIT] == mode_q[0]); // R5
   AST_DENS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      m_wr |=> dens_hd == $past(io_wdata[1])); // R7
   AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_ir3, irq_ir2}) && $onehot0({drq_ch2, drq_ch3})); // R9

endmodule

bind fdd_bridge fdd_bridge_chk #(
   .ADDR_W (ADDR_W),
   .SET_BIT(SET_BIT),
   .BASE   (BASE)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_addr  (io_addr),
   .io_wr    (io_wr),
   .io_wdata (io_wdata),
   .fdc_rst  (fdc_rst),
   .fdc_ready(fdc_ready),
   .fdc_motor(fdc_motor),
   .fdc_wr   (fdc_wr),
   .dens_hd  (dens_hd),
   .irq_ir3  (irq_ir3),
   .irq_ir2  (irq_ir2),
   .drq_ch2  (drq_ch2),
   .drq_ch3  (drq_ch3),
   .ctrl_q   (ctrl_q),
   .mode_q   (mode_q),
   .tmr_irq  (tmr_irq)
);

// File: tb/test_fdd_bridge.sv
module test_fdd_bridge;

   localparam int T_CYC = 50;
   localparam int R_LEN = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] io_addr = '0;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic       fdc_rd, fdc_wr, fdc_a0;
   logic [7:0] fdc_wdata;
   logic [7:0] fdc_rdata = '0;
   logic       fdc_rst, fdc_ready, fdc_motor;
   logic       fdc_int = 1'b0;
   logic       fdc_drq = 1'b0;
   logic       disk_in = 1'b0;
   logic       dens_hd, irq_ir3, irq_ir2, drq_ch2, drq_ch3;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fdd_bridge #(
      .ADDR_W(8), .SET_BIT(4), .BASE(8'h20),
      .TIMER_CYCLES(T_CYC), .RST_LEN(R_LEN), .HD_ON_IR3(1'b1)
   ) i_fdd_bridge (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .fdc_rd(fdc_rd), .fdc_wr(fdc_wr),
      .fdc_a0(fdc_a0), .fdc_wdata(fdc_wdata), .fdc_rdata(fdc_rdata),
      .fdc_rst(fdc_rst), .fdc_ready(fdc_ready), .fdc_motor(fdc_motor),
      .fdc_int(fdc_int), .fdc_drq(fdc_drq), .disk_in(disk_in), .dens_hd(dens_hd),
      .irq_ir3(irq_ir3), .irq_ir2(irq_ir2), .drq_ch2(drq_ch2), .drq_ch3(drq_ch3)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_port(input logic [7:0] a);
      logic [7:0] f;
      f = a & 8'hEF;
      return (f == 8'h20) || (f == 8'h22);
   endfunction

   function automatic logic [7:0] exp_rd(input logic [7:0] a, input logic [1:0] m,
                                         input logic [7:0] fr, input logic d);
      logic [7:0] f;
      f = a & 8'hEF;
      if (is_port(a))   return (a[4] == m[0]) ? fr : 8'hFF;
      if (f == 8'h24)   return 8'h64 | (d ? 8'h10 : 8'h00);
      if (a == 8'h2E)   return 8'hF8 | {6'b0, m};
      return 8'hFF;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 rst", fdc_rst, 0);
      chk("R1 ready", fdc_ready, 0);
      chk("R1 motor", fdc_motor, 0);
      chk("R1 dens", dens_hd, 0);
      chk("R1 routes", {irq_ir3, irq_ir2, drq_ch2, drq_ch3}, 0);
      io_addr = 8'h2E; io_rd = 1'b1; #1;
      chk("R1 mode read", io_rdata, 8'hF8);
      io_rd = 1'b0;

      // R5 R6 R8 R10 read sweep over all modes
      for (int m = 0; m < 4; m++) begin
         wr(8'h2E, 8'(m) | 8'hA0);
         chk("R7 dens", dens_hd, m[1]);
         for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            io_addr = 8'(a); fdc_rdata = 8'(a) ^ 8'hA5; disk_in = a[0];
            io_rd = 1'b1; #1;
            chk("R5 R6 R8 R10 rdata", io_rdata,
                exp_rd(8'(a), 2'(m), 8'(a) ^ 8'hA5, a[0]));
            chk("R5 R10 rd strobe", fdc_rd, is_port(8'(a)) && (a[4] == m[0]));
            io_rd = 1'b0;
         end
      end

      // R5 R10 write strobe sweep, write withdrawn before the clock edge
      for (int m = 0; m < 2; m++) begin
         wr(8'h2E, 8'(m));
         for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            io_addr = 8'(a); io_wdata = 8'h3C; io_wr = 1'b1; #1;
            chk("R5 R10 wr strobe", fdc_wr, is_port(8'(a)) && (a[4] == m[0]));
            if (is_port(8'(a)) && (a[4] == m[0])) begin
               chk("R5 a0", fdc_a0, a[1]);
               chk("R5 wdata", fdc_wdata, 8'h3C);
            end
            io_wr = 1'b0;
         end
      end

      // R7 density edges, R9 routing
      fdc_int = 1'b1; fdc_drq = 1'b1;
      wr(8'h2E, 8'h02);
      chk("R7 up", dens_hd, 1);
      #1 chk("R9 hd", {irq_ir3, irq_ir2, drq_ch2, drq_ch3}, 4'b1010);
      wr(8'h2E, 8'h03);
      chk("R7 hold", dens_hd, 1);
      wr(8'h2E, 8'h01);
      chk("R7 down", dens_hd, 0);
      #1 chk("R9 dd", {irq_ir3, irq_ir2, drq_ch2, drq_ch3}, 4'b0101);
      fdc_int = 1'b0; fdc_drq = 1'b0;
      #1 chk("R9 idle", {irq_ir3, irq_ir2, drq_ch2, drq_ch3}, 4'b0000);
      wr(8'h2E, 8'h00);

      // R3 lines
      wr(8'h24, 8'h48);
      chk("R3 ready", fdc_ready, 1);
      chk("R3 motor", fdc_motor, 1);
      wr(8'h34, 8'h40);
      chk("R3 motor off", fdc_motor, 0);
      chk("R3 ready on", fdc_ready, 1);
      wr(8'h24, 8'h00);
      chk("R3 ready off", fdc_ready, 0);

      // R2 reset pulse
      wr(8'h24, 8'h80);
      for (int i = 0; i < R_LEN; i++) begin
         chk("R2 pulse high", fdc_rst, 1);
         idle(1);
      end
      chk("R2 pulse end", fdc_rst, 0);
      wr(8'h24, 8'h80);
      chk("R2 no repulse", fdc_rst, 0);
      wr(8'h24, 8'h00);

      // R4 timer expiry with arm
      wr(8'h24, 8'h04);
      idle(T_CYC - 1);
      chk("R4 before expiry", irq_ir2, 0);
      idle(1);
      chk("R4 expiry", irq_ir2, 1);
      idle(5);
      chk("R4 level held", irq_ir2, 1);
      wr(8'h24, 8'h04);
      chk("R4 cleared", irq_ir2, 0);
      // R4 retrigger delays expiry
      idle(20);
      wr(8'h24, 8'h04);
      idle(T_CYC - 1);
      chk("R4 retrig before", irq_ir2, 0);
      idle(1);
      chk("R4 retrig expiry", irq_ir2, 1);
      // R4 no interrupt when unarmed
      wr(8'h24, 8'h00);
      idle(T_CYC + 3);
      chk("R4 unarmed", irq_ir2, 0);
      // R4 routed under high density
      wr(8'h2E, 8'h02);
      wr(8'h24, 8'h04);
      idle(T_CYC);
      chk("R4 R9 hd timer", {irq_ir3, irq_ir2}, 2'b10);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule